// File: doc/BRIEF.md
# Serial Boot ROM and Clock/SRAM Slave

This block is the device side of a four-wire serial link, full duplex and shifting MSB first, for a part that holds a boot ROM and a small battery-backed RTC/SRAM store. The host pulls chip select low and shifts in a 32-bit header. The header gives a direction bit, an unused bit, a target bit, a 23-bit start address and six dummy bits. The slave then streams bytes. On a read it drives ROM or RTC/SRAM bytes onto its data output. On a write it accepts bytes into the RTC/SRAM. Each byte advances the address until chip select rises.

The serial pins are sampled by the system clock through a synchronizer. The host raises the serial clock to present a bit to the slave. The slave changes its output bit after the falling edge. The serial half period must be at least `SYNC_STAGES + 3` system clocks. The address is latched as soon as its last bit arrives. The first byte is fetched while the dummy bits are still shifting, so it is ready when the data phase starts. The output has a separate enable: it is driven only while the device is selected. A rising chip select at any point abandons the transfer.

Top module: `bootser_slave`

## Requirements
- R1: `spi_miso_oe` is 0 after reset and whenever chip select has been high for more than `SYNC_STAGES + 1` clocks. It is 1 while the device is selected.
- R2: Header bit 1 (the first bit sent) selects the direction: 0 reads and 1 writes.
- R3: Header bit 2 has no effect. The same transfer with this bit at 0 or at 1 returns the same data.
- R4: Header bit 3 selects the target: 0 for ROM and 1 for RTC/SRAM. ROM byte `i` holds `((i*37) mod 256) XOR 0x5A`.
- R5: Header bits 4 to 26 hold the start address, MSB first. Bits 27 to 32 are dummy bits. The first data bit (bit 7 of the byte at the start address) appears on `spi_miso` after the falling clock edge that follows the 32nd rising edge.
- R6: The address steps by one after every eighth data bit. It wraps inside the addressed array: ROM index = address mod 2^ROM_AW, SRAM index = address mod 2^RAM_AW.
- R7: On an RTC/SRAM write, each completed data byte (MSB first) is stored at the current address.
- R8: A write aimed at the ROM stores nothing. The ROM and the SRAM read back unchanged, and the address still advances.
- R9: During a read's data phase the input bits are ignored. Data out is unaffected and nothing is stored.
- R10: A rising chip select aborts the transfer at once. A partly received header or byte is dropped, and the next selection starts a new header. When the deselect and the eighth bit's rising edge are sampled in the same clock, the abort wins and the byte is not stored.
- R11: While selected, during the header and during a write's data phase, `spi_miso` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (1 = drive, 0 = high impedance) |

## Verification
Two events can land in the same sampled clock: the deselect and the rising edge that completes a write byte. Chip select and serial clock pass through identical synchronizer chains. The bench therefore raises both pins together on the eighth bit of a write. It then reads that SRAM location back and expects the old contents, because the abort must win. It also checks the quieter overlap, where the byte-boundary commit and the next-byte prefetch share one edge. Full-array write and read sweeps across the address wrap cover that case.

// File: rtl/bootser_pkg.sv
package bootser_pkg;

  typedef enum logic [0:0] {ST_HDR = 1'b0, ST_DATA = 1'b1} bootser_state_e;

  localparam int HDR_BITS   = 32;
  localparam int CMD_BITS   = 3;
  localparam int ADDR_BITS  = 23;
  localparam int DUMMY_BITS = HDR_BITS - CMD_BITS - ADDR_BITS;
  // header bits held when the last address bit arrives
  localparam int ADDR_DONE  = CMD_BITS + ADDR_BITS;

  function automatic logic [7:0] rom_byte(input int unsigned idx);
    logic [7:0] prod;
    prod = idx[7:0] * 8'd37;
    return prod ^ 8'h5A;
  endfunction

endpackage

// File: rtl/bootser_pinsync.sv
module bootser_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic              sclk_last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_q <= '0; cs_q <= '1; mosi_q <= '0;
        end else begin
          sclk_q <= sclk_i; cs_q <= cs_n_i; mosi_q <= mosi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_q <= '0; cs_q <= '1; mosi_q <= '0;
        end else begin
          sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
          cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
          mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_last <= 1'b0;
    else     sclk_last <= sclk_q[MSB];
  end

  assign sclk_rise = sclk_q[MSB] & ~sclk_last;
  assign sclk_fall = ~sclk_q[MSB] & sclk_last;
  assign cs_act    = ~cs_q[MSB];
  assign mosi_s    = mosi_q[MSB];

endmodule

// File: rtl/bootser_mem.sv
module bootser_mem #(
  parameter int ROM_AW = 8,
  parameter int RAM_AW = 6,
  localparam int KEEP_AW   = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW,
  localparam int ROM_DEPTH = 1 << ROM_AW,
  localparam int RAM_DEPTH = 1 << RAM_AW
) (
  input  logic               clk,
  input  logic               rd_ram,
  input  logic [KEEP_AW-1:0] rd_addr,
  output logic [7:0]         rd_data,
  input  logic               wr_en,
  input  logic [RAM_AW-1:0]  wr_addr,
  input  logic [7:0]         wr_data
);
  import bootser_pkg::*;

  logic [7:0] rom [ROM_DEPTH];
  logic [7:0] ram [RAM_DEPTH];
  logic [7:0] rom_q, ram_q;
  logic       sel_q;

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom[i] = rom_byte(i);
    for (int i = 0; i < RAM_DEPTH; i++) ram[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    rom_q <= rom[rd_addr[ROM_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
    ram_q <= ram[rd_addr[RAM_AW-1:0]];
  end

  always_ff @(posedge clk) sel_q <= rd_ram;

  assign rd_data = sel_q ? ram_q : rom_q;

endmodule

// File: rtl/bootser_fsm.sv
module bootser_fsm #(
  parameter int ROM_AW = 8,
  parameter int RAM_AW = 6,
  localparam int KEEP_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_act,
  input  logic               mosi,
  input  logic [7:0]         rd_data,
  output logic               miso,
  output logic               miso_oe,
  output logic               fetch_ram,
  output logic [KEEP_AW-1:0] fetch_addr,
  output logic               mem_we,
  output logic [RAM_AW-1:0]  mem_waddr,
  output logic [7:0]         mem_wdata,
  output logic               in_data,
  output logic [5:0]         hdr_cnt,
  output logic [KEEP_AW-1:0] cur_addr
);
  import bootser_pkg::*;

  localparam int HB = ADDR_DONE - 1;          // header bits held before last address bit
  localparam int DIR_POS = HB - 1;
  localparam int TGT_POS = HB - CMD_BITS;

  bootser_state_e     state;
  logic [HB-1:0]      hdr;
  logic [5:0]         hcnt;
  logic [2:0]         dcnt;
  logic               is_wr, is_ram;
  logic [KEEP_AW-1:0] addr;
  logic [7:0]         cur_byte;
  logic [6:0]         rx;
  logic               miso_q, oe_q, we_q;
  logic [RAM_AW-1:0]  waddr_q;
  logic [7:0]         wdata_q;
  logic [KEEP_AW-1:0] faddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HDR;
      hdr      <= '0;
      hcnt     <= '0;
      dcnt     <= '0;
      is_wr    <= 1'b0;
      is_ram   <= 1'b0;
      addr     <= '0;
      cur_byte <= '0;
      rx       <= '0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      faddr_q  <= '0;
    end else begin
      we_q <= 1'b0;
      oe_q <= cs_act;
      if (!cs_act) begin
        state  <= ST_HDR;
        hcnt   <= '0;
        dcnt   <= '0;
        miso_q <= 1'b0;
      end else if (sclk_rise) begin
        if (state == ST_HDR) begin
          hdr  <= {hdr[HB-2:0], mosi};
          hcnt <= hcnt + 6'd1;
          if (hcnt == 6'(HB)) begin
            is_wr   <= hdr[DIR_POS];
            is_ram  <= hdr[TGT_POS];
            addr    <= {hdr[KEEP_AW-2:0], mosi};
            faddr_q <= {hdr[KEEP_AW-2:0], mosi};
          end
          if (hcnt == 6'(HDR_BITS - 1)) begin
            state    <= ST_DATA;
            dcnt     <= '0;
            cur_byte <= rd_data;
            faddr_q  <= addr + 1'b1;
          end
        end else begin
          dcnt <= dcnt + 3'd1;
          rx   <= {rx[5:0], mosi};
          if (dcnt == 3'd7) begin
            addr     <= addr + 1'b1;
            cur_byte <= rd_data;
            faddr_q  <= addr + 2'd2;
            if (is_wr && is_ram) begin
              we_q    <= 1'b1;
              waddr_q <= addr[RAM_AW-1:0];
              wdata_q <= {rx, mosi};
            end
          end
        end
      end else if (sclk_fall && state == ST_DATA && !is_wr) begin
        miso_q <= cur_byte[~dcnt];
      end
    end
  end

  assign miso       = miso_q;
  assign miso_oe    = oe_q;
  assign fetch_ram  = is_ram;
  assign fetch_addr = faddr_q;
  assign mem_we     = we_q;
  assign mem_waddr  = waddr_q;
  assign mem_wdata  = wdata_q;
  assign in_data    = (state == ST_DATA);
  assign hdr_cnt    = hcnt;
  assign cur_addr   = addr;

endmodule

// File: rtl/bootser_slave.sv
module bootser_slave #(
  parameter int ROM_AW      = 8,
  parameter int RAM_AW      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int KEEP_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic               sclk_rise, sclk_fall, cs_act, mosi_s;
  logic [7:0]         rd_data;
  logic               fetch_ram;
  logic [KEEP_AW-1:0] fetch_addr;
  logic               mem_we;
  logic [RAM_AW-1:0]  mem_waddr;
  logic [7:0]         mem_wdata;
  logic               in_data;
  logic [5:0]         hdr_cnt;
  logic [KEEP_AW-1:0] cur_addr;

  bootser_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  bootser_fsm #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_fsm (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi(mosi_s), .rd_data(rd_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe),
    .fetch_ram(fetch_ram), .fetch_addr(fetch_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .in_data(in_data), .hdr_cnt(hdr_cnt), .cur_addr(cur_addr)
  );

  bootser_mem #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_mem (
    .clk(clk),
    .rd_ram(fetch_ram), .rd_addr(fetch_addr), .rd_data(rd_data),
    .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
  );

endmodule

// File: rtl/bootser_chk.sv
module bootser_chk #(
  parameter int KEEP_AW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               spi_cs_n,
  input logic               spi_miso,
  input logic               spi_miso_oe,
  input logic               cs_act,
  input logic               in_data,
  input logic [5:0]         hdr_cnt,
  input logic [KEEP_AW-1:0] cur_addr,
  input logic               mem_we
);
  localparam int LAT = SYNC_STAGES + 1;

  logic [3:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)           hi_run <= '0;
    else if (!spi_cs_n) hi_run <= '0;
    else if (hi_run != 4'hF) hi_run <= hi_run + 4'd1;
  end

  // R1
  a_r1_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && hi_run >= 4'(LAT)) |-> !spi_miso_oe);

  // R11
  a_r11_quiet_header: assert property (@(posedge clk) disable iff (rst)
    !in_data |-> (spi_miso == 1'b0));

  // R6
  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    (in_data && $past(in_data) && cur_addr != $past(cur_addr))
      |-> cur_addr == $past(cur_addr) + 1'b1);

  // R7
  a_r7_write_in_data: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(in_data));

  // R10
  a_r10_abort_resets: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!in_data && hdr_cnt == 6'd0));

  // R5
  a_r5_data_after_header: assert property (@(posedge clk) disable iff (rst)
    (in_data && !$past(in_data)) |-> $past(hdr_cnt) == 6'd31);

endmodule

bind bootser_slave bootser_chk #(.KEEP_AW(KEEP_AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .spi_miso_oe(spi_miso_oe), .cs_act(cs_act), .in_data(in_data),
  .hdr_cnt(hdr_cnt), .cur_addr(cur_addr), .mem_we(mem_we)
);

// File: tb/test_bootser_slave.sv
module test_bootser_slave;
  localparam int HALF = 8;
  localparam int RAMD = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_ram [RAMD];
  logic [7:0] got;

  always #2 clk = ~clk;

  bootser_slave i_bootser_slave (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  function automatic logic [7:0] rom_exp(input int a);
    int v;
    v = ((a % 256) * 37) % 256;
    return 8'(v) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic mo, output logic mi);
    mosi = mo;
    wait_clk(HALF);
    mi = miso;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic header(input logic wr, input logic b2, input logic tgt, input logic [22:0] a);
    logic [31:0] w;
    logic mi;
    logic any_hi;
    w = {wr, b2, tgt, a, 6'b000000};
    any_hi = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      spi_bit(w[i], mi);
      any_hi = any_hi | mi;
    end
    check("R11 header output low", any_hi, 1'b0);
  endtask

  task automatic xbyte(input logic [7:0] o, output logic [7:0] in);
    logic mi;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(o[i], mi);
      in[i] = mi;
    end
  endtask

  task automatic ram_write(input int a, input int n, input int seed);
    logic [7:0] d, dummy;
    sel();
    header(1'b1, 1'b0, 1'b1, 23'(a));
    for (int k = 0; k < n; k++) begin
      d = 8'((seed + k * 29) ^ 8'hC3);
      xbyte(d, dummy);
      exp_ram[(a + k) % RAMD] = d;
      check("R11 write phase output low", dummy, 8'h00);
    end
    desel();
  endtask

  task automatic ram_read(input string req, input int a, input int n, input logic [7:0] fill);
    sel();
    header(1'b0, 1'b0, 1'b1, 23'(a));
    for (int k = 0; k < n; k++) begin
      xbyte(fill, got);
      check(req, got, exp_ram[(a + k) % RAMD]);
    end
    desel();
  endtask

  initial begin
    logic mi;
    for (int i = 0; i < RAMD; i++) exp_ram[i] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    check("R1 reset oe", miso_oe, 1'b0);
    check("R1 reset miso", miso, 1'b0);

    // R4 R5 R6: full ROM sweep from 0 across the wrap
    sel();
    check("R1 oe when selected", miso_oe, 1'b1);
    header(1'b0, 1'b0, 1'b0, 23'd0);
    for (int k = 0; k < 260; k++) begin
      xbyte(8'h00, got);
      check("R4 R5 R6 rom sweep", got, rom_exp(k));
    end
    desel();
    check("R1 oe after deselect", miso_oe, 1'b0);

    // R3 R9: unused bit set, inputs all ones, high address bits dropped
    sel();
    header(1'b0, 1'b1, 1'b0, 23'h7FFFF0);
    for (int k = 0; k < 20; k++) begin
      xbyte(8'hFF, got);
      check("R3 R9 R6 rom high address", got, rom_exp(8'hF0 + k));
    end
    desel();

    // R7 R6: fill whole SRAM from 60 with wrap, then read back all
    ram_write(60, RAMD, 7);
    ram_read("R7 R2 sram sweep", 0, RAMD, 8'h00);
    ram_write(62, 5, 101);
    ram_read("R7 R6 sram wrap", 62, 5, 8'h00);

    // R9: read SRAM with input ones, then verify nothing changed
    ram_read("R9 read ignores input", 10, 4, 8'hFF);
    ram_read("R9 sram unchanged", 10, 4, 8'h00);

    // R8: write aimed at ROM
    sel();
    header(1'b1, 1'b0, 1'b0, 23'd5);
    for (int k = 0; k < 4; k++) xbyte(8'hEE, got);
    desel();
    sel();
    header(1'b0, 1'b0, 1'b0, 23'd5);
    for (int k = 0; k < 4; k++) begin
      xbyte(8'h00, got);
      check("R8 rom unchanged", got, rom_exp(5 + k));
    end
    desel();
    ram_read("R8 sram unchanged", 5, 4, 8'h00);

    // R10: partial header then fresh transfer
    sel();
    for (int i = 0; i < 10; i++) spi_bit(1'b1, mi);
    desel();
    sel();
    header(1'b0, 1'b0, 1'b0, 23'd33);
    xbyte(8'h00, got);
    check("R10 after aborted header", got, rom_exp(33));
    desel();

    // R10: one full byte then a partial byte
    sel();
    header(1'b1, 1'b0, 1'b1, 23'd20);
    xbyte(8'h11, got);
    for (int i = 0; i < 5; i++) spi_bit(1'b1, mi);
    desel();
    exp_ram[20] = 8'h11;
    ram_read("R10 partial byte dropped", 20, 2, 8'h00);

    // R10: deselect sampled together with eighth rising edge
    sel();
    header(1'b1, 1'b0, 1'b1, 23'd30);
    for (int i = 7; i >= 1; i--) spi_bit(1'b1, mi);
    mosi = 1'b1;
    wait_clk(HALF);
    sclk = 1'b1;
    cs_n = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(2 * HALF);
    ram_read("R10 abort beats commit", 30, 1, 8'h00);

    // R2: direction bit 1 on SRAM stores, bit 0 only reads
    ram_write(40, 2, 55);
    ram_read("R2 write then read", 40, 2, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule